// File: doc/BRIEF.md
# Per-Source Interrupt Destination Router with Owner-Fenced Merge Sets

This block takes a bank of level-high interrupt sources and sends each one to a single destination, picked by a 3-bit select that belongs to that source. Five of the destinations are shared merge sets. Three of these sets serve the main application processor, one serves the first secondary controller and one serves the second secondary controller. Each set folds its member sources into one level output. The other destinations are:

- a per-source forward line into an upstream router, which lets the main processor re-steer the source there at run time;
- a per-source dedicated line to the boot controller;
- a "none" code that drops the source.

Each merge set has two registers: an enable mask, and a raw view that shows which of its routed sources are high right now. The output of a set is high when any enabled raw bit is high. A single-cycle register bus carries a requester ID with every access. Each register window answers only to the processor that owns it:

- the main processor owns sets 0 to 2;
- secondary controller 0 owns set 3;
- secondary controller 1 owns set 4;
- the boot-firmware requester owns the route-select words.

Any other access is refused and raises an error pulse.

Top module: `irq_dest_router`

## Requirements
- R1: Source i is routed by a 3-bit code held in route word 0x80+4*(i/8), in bits 4*(i%8)+2..4*(i%8). Bit 4*(i%8)+3 reads back as zero. Codes 0 to 4 select merge set 0 to 4, code 5 selects the forward line fwdIrq[i], code 6 selects the boot line bootIrq[i], and code 7 selects no output.
- R2: setIrq[k] is high when any bit of (raw status of set k AND enable of set k) is high. Bit k of setIrq carries set k.
- R3: The raw status register of set k is at byte 0x10*k+4. Bit i reads as 1 when source i is high and is routed to set k. The register is read-only, and a write to it changes nothing and raises no error.
- R4: The enable register of set k is at byte 0x10*k+0. Its owner can write it and read the written value back.
- R5: Ownership is by requester ID (busId): ID 0 owns sets 0, 1 and 2, ID 1 owns set 3, ID 2 owns set 4, and ID 3 owns the route words.
- R6: A write from a requester that does not own the target leaves every enable and route register unchanged.
- R7: A read from a requester that does not own the target returns zero. Any refused access makes busErr high for exactly the one cycle in which the response is due.
- R8: After reset, every route code is 6 (boot line), every enable bit is 0, and all outputs, including busErr, are low.
- R9: setIrq, fwdIrq and bootIrq follow a change on srcIrq exactly one clock later and not before.
- R10: An address that lies in no window counts as a refused access: it returns zero and raises busErr. This covers offsets other than 0 and 4 in a set window, set windows 5 to 7, and route words at or beyond N_SRC/8.
- R11: fwdIrq[i] and bootIrq[i] follow source i as a registered level while the source's code selects that line, and are low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcIrq | input | N_SRC | Level-high interrupt sources |
| busEn | input | 1 | Register access strobe, one cycle per access |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 8 | Byte address |
| busId | input | 2 | Requester ID |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid the cycle after the access, zero otherwise |
| busErr | output | 1 | Refused-access pulse, aligned with busRdata |
| setIrq | output | 5 | Merged level output of each merge set |
| fwdIrq | output | N_SRC | Per-source forward lines into the upstream router |
| bootIrq | output | N_SRC | Per-source dedicated boot-controller lines |

## Verification
Every result of this block is due one clock edge after its cause:

- read data and the error pulse appear at the edge after the access edge;
- interrupt outputs appear at the edge after the source change.

The driver therefore queues each expected item right after the edge that captures its stimulus. The monitor pops and compares it on the following falling edge, so a result that arrives early or late is a miscompare. One dedicated check samples the outputs between a source change and the next edge, to show that they still hold the old value. After every write, the bench leaves at least one idle cycle before an interrupt check, because the merged output needs a second edge to reflect new enables.

// File: rtl/irq_route_pkg.sv
`timescale 1ns/1ps
package irq_route_pkg;
  localparam int SET_CNT = 5;
  localparam int DEST_W = 3;
  localparam int ID_W = 2;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int SLOTS_PER_WORD = DATA_W / 4;

  typedef enum logic [DEST_W-1:0] {
    DST_MAIN0 = 3'd0,
    DST_MAIN1 = 3'd1,
    DST_MAIN2 = 3'd2,
    DST_SEC0  = 3'd3,
    DST_SEC1  = 3'd4,
    DST_FWD   = 3'd5,
    DST_BOOT  = 3'd6,
    DST_NONE  = 3'd7
  } dest_e;

  typedef enum logic [ID_W-1:0] {
    RID_MAIN = 2'd0,
    RID_SEC0 = 2'd1,
    RID_SEC1 = 2'd2,
    RID_FW   = 2'd3
  } reqId_e;

  typedef enum logic [1:0] {
    RK_ZERO = 2'd0,
    RK_EN   = 2'd1,
    RK_RAW  = 2'd2,
    RK_SEL  = 2'd3
  } rdKind_e;

  typedef struct packed {
    logic    enWr;
    logic    selWr;
    logic    rdEn;
    rdKind_e rdKind;
    logic [2:0] setIdx;
    logic [4:0] wordIdx;
  } regStrobe_t;
endpackage

// File: rtl/irq_route_ctrl.sv
`timescale 1ns/1ps
module irq_route_ctrl
  import irq_route_pkg::*;
#(
  parameter int N_SEL_WORDS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busEn,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [ID_W-1:0]   busId,
  output regStrobe_t        strb,
  output logic              accErr
);
  logic       inRouteArea;
  logic [2:0] setIdx;
  logic [4:0] wordIdx;
  logic [3:0] winOff;
  logic       mapped;
  logic       allowed;
  reqId_e     owner;
  rdKind_e    kind;
  logic       errQ;

  assign inRouteArea = busAddr[7];
  assign setIdx      = busAddr[6:4];
  assign wordIdx     = busAddr[6:2];
  assign winOff      = busAddr[3:0];

  always_comb begin
    mapped = 1'b0;
    owner  = RID_FW;
    kind   = RK_ZERO;
    if (inRouteArea) begin
      mapped = (32'(wordIdx) < N_SEL_WORDS);
      owner  = RID_FW;
      kind   = RK_SEL;
    end else begin
      mapped = (32'(setIdx) < SET_CNT) && ((winOff == 4'h0) || (winOff == 4'h4));
      if (setIdx < 3'd3)       owner = RID_MAIN;
      else if (setIdx == 3'd3) owner = RID_SEC0;
      else                     owner = RID_SEC1;
      kind = (winOff == 4'h0) ? RK_EN : RK_RAW;
    end
  end

  assign allowed = mapped && (busId == owner);

  always_comb begin
    strb.enWr    = busEn && busWr && allowed && (kind == RK_EN);
    strb.selWr   = busEn && busWr && allowed && (kind == RK_SEL);
    strb.rdEn    = busEn && !busWr;
    strb.rdKind  = allowed ? kind : RK_ZERO;
    strb.setIdx  = setIdx;
    strb.wordIdx = wordIdx;
  end

  always_ff @(posedge clk) begin
    if (!rstN) errQ <= 1'b0;
    else       errQ <= busEn && !allowed;
  end

  assign accErr = errQ;

  // R7
  err_needs_access_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busEn |=> !accErr);

  // R5
  granted_write_no_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.enWr || strb.selWr) |=> !accErr);
endmodule

// File: rtl/irq_route_dp.sv
`timescale 1ns/1ps
module irq_route_dp
  import irq_route_pkg::*;
#(
  parameter int N_SRC = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [N_SRC-1:0]   srcIrq,
  input  regStrobe_t         strb,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata,
  output logic [SET_CNT-1:0] setIrq,
  output logic [N_SRC-1:0]   fwdIrq,
  output logic [N_SRC-1:0]   bootIrq
);
  logic [N_SRC-1:0][DEST_W-1:0]  selQ;
  logic [SET_CNT-1:0][N_SRC-1:0] enQ;
  logic [SET_CNT-1:0][N_SRC-1:0] rawSet;
  logic [N_SRC-1:0]              fwdRaw;
  logic [N_SRC-1:0]              bootRaw;
  logic [SET_CNT-1:0]            setIrqQ;
  logic [N_SRC-1:0]              fwdQ;
  logic [N_SRC-1:0]              bootQ;
  logic [DATA_W-1:0]             rdVal;
  logic [DATA_W-1:0]             rdataQ;

  for (genvar k = 0; k < SET_CNT; k++) begin : g_setRaw
    for (genvar i = 0; i < N_SRC; i++) begin : g_bit
      assign rawSet[k][i] = srcIrq[i] && (selQ[i] == DEST_W'(k));
    end
  end

  for (genvar i = 0; i < N_SRC; i++) begin : g_line
    assign fwdRaw[i]  = srcIrq[i] && (selQ[i] == DST_FWD);
    assign bootRaw[i] = srcIrq[i] && (selQ[i] == DST_BOOT);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enQ  <= '0;
      selQ <= {N_SRC{DST_BOOT}};
    end else begin
      for (int k = 0; k < SET_CNT; k++) begin
        if (strb.enWr && (strb.setIdx == 3'(k))) enQ[k] <= wdata[N_SRC-1:0];
      end
      for (int i = 0; i < N_SRC; i++) begin
        if (strb.selWr && (strb.wordIdx == 5'(i / SLOTS_PER_WORD)))
          selQ[i] <= wdata[4*(i % SLOTS_PER_WORD) +: DEST_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      setIrqQ <= '0;
      fwdQ    <= '0;
      bootQ   <= '0;
    end else begin
      for (int k = 0; k < SET_CNT; k++) setIrqQ[k] <= |(rawSet[k] & enQ[k]);
      fwdQ  <= fwdRaw;
      bootQ <= bootRaw;
    end
  end

  always_comb begin
    rdVal = '0;
    case (strb.rdKind)
      RK_EN: begin
        for (int k = 0; k < SET_CNT; k++)
          if (strb.setIdx == 3'(k)) rdVal[N_SRC-1:0] = enQ[k];
      end
      RK_RAW: begin
        for (int k = 0; k < SET_CNT; k++)
          if (strb.setIdx == 3'(k)) rdVal[N_SRC-1:0] = rawSet[k];
      end
      RK_SEL: begin
        for (int j = 0; j < SLOTS_PER_WORD; j++) begin
          if (int'(strb.wordIdx) * SLOTS_PER_WORD + j < N_SRC)
            rdVal[4*j +: DEST_W] = selQ[int'(strb.wordIdx) * SLOTS_PER_WORD + j];
        end
      end
      default: rdVal = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)          rdataQ <= '0;
    else if (strb.rdEn) rdataQ <= rdVal;
    else                rdataQ <= '0;
  end

  assign rdata   = rdataQ;
  assign setIrq  = setIrqQ;
  assign fwdIrq  = fwdQ;
  assign bootIrq = bootQ;

  // R6
  en_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.enWr |=> $stable(enQ));

  // R6
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.selWr |=> $stable(selQ));

  // R7
  zero_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdEn && (strb.rdKind == RK_ZERO)) |=> (rdata == '0));

  for (genvar k = 0; k < SET_CNT; k++) begin : g_mergeChk
    // R2
    merge_off_chk: assert property (@(posedge clk) disable iff (!rstN)
      (enQ[k] == '0) |=> !setIrq[k]);
  end
endmodule

// File: rtl/irq_dest_router.sv
`timescale 1ns/1ps
module irq_dest_router
  import irq_route_pkg::*;
#(
  parameter int N_SRC = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [N_SRC-1:0]   srcIrq,
  input  logic               busEn,
  input  logic               busWr,
  input  logic [7:0]         busAddr,
  input  logic [1:0]         busId,
  input  logic [31:0]        busWdata,
  output logic [31:0]        busRdata,
  output logic               busErr,
  output logic [4:0]         setIrq,
  output logic [N_SRC-1:0]   fwdIrq,
  output logic [N_SRC-1:0]   bootIrq
);
  localparam int N_SEL_WORDS = (N_SRC + SLOTS_PER_WORD - 1) / SLOTS_PER_WORD;

  regStrobe_t strb;

  irq_route_ctrl #(.N_SEL_WORDS(N_SEL_WORDS)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .busEn   (busEn),
    .busWr   (busWr),
    .busAddr (busAddr),
    .busId   (busId),
    .strb    (strb),
    .accErr  (busErr)
  );

  irq_route_dp #(.N_SRC(N_SRC)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .srcIrq  (srcIrq),
    .strb    (strb),
    .wdata   (busWdata),
    .rdata   (busRdata),
    .setIrq  (setIrq),
    .fwdIrq  (fwdIrq),
    .bootIrq (bootIrq)
  );
endmodule

// File: tb/tb_irq_dest_router.sv
`timescale 1ns/1ps
module tb_irq_dest_router;
  localparam int NS = 32;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rstN;
  logic [NS-1:0] srcIrq;
  logic          busEn, busWr;
  logic [7:0]    busAddr;
  logic [1:0]    busId;
  logic [31:0]   busWdata;
  logic [31:0]   busRdata;
  logic          busErr;
  logic [4:0]    setIrq;
  logic [NS-1:0] fwdIrq, bootIrq;

  irq_dest_router #(.N_SRC(NS)) dut (
    .clk(clk), .rstN(rstN), .srcIrq(srcIrq), .busEn(busEn), .busWr(busWr),
    .busAddr(busAddr), .busId(busId), .busWdata(busWdata), .busRdata(busRdata),
    .busErr(busErr), .setIrq(setIrq), .fwdIrq(fwdIrq), .bootIrq(bootIrq)
  );

  typedef struct {
    bit            isBus;
    logic [31:0]   rd;
    logic          err;
    logic [4:0]    setV;
    logic [NS-1:0] fwd;
    logic [NS-1:0] boot;
    string         tag;
  } item_t;

  item_t q[$];
  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic [2:0]    selM [NS];
  logic [NS-1:0] enM  [5];
  logic [NS-1:0] srcM;

  function automatic logic [NS-1:0] rawOf(int k, logic [NS-1:0] s);
    logic [NS-1:0] r = '0;
    for (int i = 0; i < NS; i++) r[i] = s[i] && (selM[i] == 3'(k));
    return r;
  endfunction

  function automatic item_t irqExp(logic [NS-1:0] s, string tag);
    item_t it;
    it.isBus = 0; it.rd = '0; it.err = 1'b0; it.tag = tag;
    for (int k = 0; k < 5; k++) it.setV[k] = |(rawOf(k, s) & enM[k]);
    for (int i = 0; i < NS; i++) begin
      it.fwd[i]  = s[i] && (selM[i] == 3'd5);
      it.boot[i] = s[i] && (selM[i] == 3'd6);
    end
    return it;
  endfunction

  task automatic acc(input logic [1:0] id, input bit wr, input logic [7:0] addr,
                     input logic [31:0] wd, input string tag);
    item_t it;
    bit ok;
    int kind;
    int s, w;
    logic [1:0] own;
    it.isBus = 1; it.rd = '0; it.setV = '0; it.fwd = '0; it.boot = '0; it.tag = tag;
    s = int'(addr[6:4]);
    w = int'(addr[6:2]);
    if (addr[7]) begin
      ok = (w < NS / 8) && (id == 2'd3);
      kind = 3;
    end else begin
      own = (s < 3) ? 2'd0 : ((s == 3) ? 2'd1 : 2'd2);
      ok = (s < 5) && ((addr[3:0] == 4'h0) || (addr[3:0] == 4'h4)) && (id == own);
      kind = (addr[3:0] == 4'h0) ? 1 : 2;
    end
    it.err = !ok;
    if (ok && !wr) begin
      if (kind == 1) it.rd[NS-1:0] = enM[s];
      else if (kind == 2) it.rd[NS-1:0] = rawOf(s, srcM);
      else for (int j = 0; j < 8; j++) it.rd[4*j +: 3] = selM[w*8 + j];
    end
    @(negedge clk);
    busEn = 1'b1; busWr = wr; busAddr = addr; busId = id; busWdata = wd;
    @(posedge clk);
    q.push_back(it);
    if (ok && wr) begin
      if (kind == 1) enM[s] = wd[NS-1:0];
      else if (kind == 3) for (int j = 0; j < 8; j++) selM[w*8 + j] = wd[4*j +: 3];
    end
  endtask

  task automatic setSrc(input logic [NS-1:0] v, input string tag);
    @(negedge clk);
    busEn = 1'b0; busWr = 1'b0;
    srcIrq = v;
    @(posedge clk);
    srcM = v;
    q.push_back(irqExp(v, tag));
  endtask

  task automatic idle(input int n);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      busEn = 1'b0; busWr = 1'b0;
    end
  endtask

  task automatic lateCheck(input logic [NS-1:0] v);
    item_t old;
    idle(2);
    old = irqExp(srcM, "R9");
    @(negedge clk);
    srcIrq = v;
    #1;
    checks++;
    if (setIrq !== old.setV || fwdIrq !== old.fwd || bootIrq !== old.boot) begin
      fails++;
      $display("FAIL R9 early change: set=%h fwd=%h boot=%h exp set=%h fwd=%h boot=%h",
               setIrq, fwdIrq, bootIrq, old.setV, old.fwd, old.boot);
    end
    @(posedge clk);
    srcM = v;
    q.push_back(irqExp(v, "R9"));
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (it.isBus) begin
        if (busRdata !== it.rd || busErr !== it.err) begin
          fails++;
          $display("FAIL %s bus: rdata=%h err=%b exp rdata=%h err=%b",
                   it.tag, busRdata, busErr, it.rd, it.err);
        end
      end else begin
        if (setIrq !== it.setV || fwdIrq !== it.fwd || bootIrq !== it.boot || busErr !== 1'b0) begin
          fails++;
          $display("FAIL %s irq: set=%h fwd=%h boot=%h err=%b exp set=%h fwd=%h boot=%h err=0",
                   it.tag, setIrq, fwdIrq, bootIrq, busErr, it.setV, it.fwd, it.boot);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NS; i++) selM[i] = 3'd6;
    for (int k = 0; k < 5; k++) enM[k] = '0;
    srcM = '0;
    rstN = 1'b0; srcIrq = '0; busEn = 1'b0; busWr = 1'b0;
    busAddr = '0; busId = '0; busWdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R8 reset state
    setSrc('0, "R8");
    acc(2'd0, 0, 8'h00, '0, "R8");
    acc(2'd3, 0, 8'h80, '0, "R8");
    // R11 boot lines after reset routing
    setSrc(32'h0000_FFFF, "R11");
    setSrc(32'h0000_FFFF, "R11");

    // R1 route programming
    acc(2'd3, 1, 8'h80, 32'h0000_0000, "R1");
    acc(2'd3, 1, 8'h84, 32'h3333_3333, "R1");
    acc(2'd3, 1, 8'h88, 32'h5555_5555, "R1");
    acc(2'd3, 1, 8'h8C, 32'h6666_7421, "R1");
    acc(2'd3, 0, 8'h8C, '0, "R1");

    // R4 enables
    acc(2'd0, 1, 8'h00, 32'h0000_00F0, "R4");
    acc(2'd0, 0, 8'h00, '0, "R4");
    acc(2'd0, 1, 8'h10, 32'hFFFF_FFFF, "R4");
    acc(2'd0, 1, 8'h20, 32'hFFFF_FFFF, "R4");
    acc(2'd1, 1, 8'h30, 32'hFFFF_FFFF, "R4");
    acc(2'd2, 1, 8'h40, 32'hFFFF_FFFF, "R4");
    acc(2'd1, 0, 8'h30, '0, "R4");

    // R2 masked vs unmasked
    setSrc(32'h0000_000F, "R2");
    setSrc(32'h0000_000F, "R2");
    acc(2'd0, 0, 8'h04, '0, "R3");
    setSrc(32'h0000_0010, "R2");
    setSrc(32'h0000_0010, "R2");
    setSrc(32'hFFFF_FFFF, "R1");
    setSrc(32'hFFFF_FFFF, "R1");

    // R3 raw status and write attempt
    acc(2'd1, 0, 8'h34, '0, "R3");
    acc(2'd1, 1, 8'h34, 32'h0, "R3");
    acc(2'd1, 0, 8'h34, '0, "R3");

    // R6 foreign writes
    acc(2'd1, 1, 8'h00, 32'hFFFF_FFFF, "R6");
    acc(2'd0, 0, 8'h00, '0, "R6");
    acc(2'd0, 1, 8'h80, 32'h7777_7777, "R6");
    acc(2'd3, 0, 8'h80, '0, "R6");

    // R7 foreign read and single-cycle pulse
    acc(2'd0, 0, 8'h40, '0, "R7");
    setSrc(32'hFFFF_FFFF, "R7");
    acc(2'd2, 0, 8'h00, '0, "R7");

    // R10 unmapped addresses
    acc(2'd0, 0, 8'h08, '0, "R10");
    acc(2'd0, 0, 8'h50, '0, "R10");
    acc(2'd3, 0, 8'h90, '0, "R10");

    // R5 owners of sets 1 and 2
    acc(2'd0, 0, 8'h14, '0, "R5");
    acc(2'd2, 0, 8'h24, '0, "R5");

    // R11 forward line after re-route of source 4
    acc(2'd3, 1, 8'h80, 32'h0005_0000, "R11");
    setSrc(32'h0000_0010, "R11");
    setSrc(32'h0000_0010, "R11");

    // R9 exact latency
    lateCheck(32'h0100_0000);
    lateCheck(32'h0000_0000);

    idle(3);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule